// File: doc/BRIEF.md
# Two-Stage Selectable Bit Permutation Unit

This block permutes the bits of a 64-bit word by passing it through two switching stages taken from a six-stage butterfly network. The instruction's sub-operation field supplies two 3-bit selectors. Each selector names one stage type, numbered 0 to 5. The stages are applied in order: the first selector's stage acts first, and the second acts on its output. A 64-bit configuration word drives the 2:1 exchange switches of both stages, with 32 bits for each stage.

Any pair of stage types can be chosen for each operation. As a result, the same datapath can serve as either half of a Benes network. Software chains six operations, each one using the previous result, with the selector pairs (5,4), (3,2), (1,0), (0,1), (2,3), (4,5). This sequence reaches any arrangement of the 64 bits. Because each step depends on the result of the one before, the sequence takes six cycles.

The result is registered. It appears one cycle after an input strobe, together with a valid flag.

Top module: `perm2_unit`

## Requirements
- R1: While `rst_n` is low, and after reset is released until the first accepted strobe, `res_vld` is 0.
- R2: When `op_vld` is high at a clock edge, `res_vld` is high after that edge and `res_data` holds the result of that operation. When `op_vld` is low at an edge, `res_vld` is 0 after that edge and `res_data` keeps its previous value. Back-to-back strobes give back-to-back results.
- R3: Stage s pairs two bit positions whose indices differ only in bit s. The pair's switch number k (0..31) is the index with bit s removed. A control bit of 1 exchanges the two bits and 0 passes them straight. The number of ones in the word is never changed.
- R4: Configuration bits [63:32] control the stage named by `sel_first`. Bits [31:0] control the stage named by `sel_second`. The `sel_first` stage acts before the `sel_second` stage, so swapping the selectors can change the result.
- R5: A selector value of 6 or 7 makes that stage pass its input unchanged. With both selectors at 6 or 7, `res_data` equals `op_data`.
- R6: A configuration word of all zeros returns the data unchanged, whatever stages are selected.
- R7: Six chained operations with selector pairs (5,4), (3,2), (1,0), (0,1), (2,3), (4,5) and random configuration words match a bit-level reference of the Benes network. A single set bit stays a single set bit after the chain.
- R8: Selecting the same stage twice with equal control halves returns the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Operation strobe |
| op_data | input | 64 | Word to permute |
| op_cfg | input | 64 | Switch controls: [63:32] first stage, [31:0] second stage |
| sel_first | input | 3 | Stage type applied first (6 or 7: pass) |
| sel_second | input | 3 | Stage type applied second (6 or 7: pass) |
| res_vld | output | 1 | Result valid, one cycle after `op_vld` |
| res_data | output | 64 | Permuted word |

## Verification
The block keeps no state between operations other than the result register. A wrong switch index mapping, a swapped half of the configuration word, or a bad selector decode shows up as bits in the wrong positions of `res_data`. This error appears on the very next cycle after the faulty operation. In a six-step chain, the error carries forward into every later step and so is amplified. A fault in the valid pipeline shows up on `res_vld` one cycle after the strobe, or it shows up as `res_data` changing while no operation is accepted.

// File: rtl/perm2_pkg.sv
package perm2_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SEL_W  = 3;
  typedef logic [SEL_W-1:0] stage_sel_t;
endpackage

// File: rtl/perm_sel_decode.sv
module perm_sel_decode #(
  parameter int unsigned LG   = 6,
  parameter int unsigned SELW = 3
) (
  input  logic [SELW-1:0] sel,
  output logic [LG-1:0]   hot
);
  // one-hot stage enable; out-of-range codes select no stage (pass)
  for (genvar g = 0; g < LG; g++) begin : g_dec
    assign hot[g] = (sel == SELW'(g));
  end
endmodule

// File: rtl/perm_stage.sv
module perm_stage #(
  parameter int unsigned W    = 64,
  parameter int unsigned SELW = 3,
  localparam int unsigned LG   = $clog2(W),
  localparam int unsigned HALF = W / 2
) (
  input  logic [W-1:0]    din,
  input  logic [SELW-1:0] sel,
  input  logic [HALF-1:0] ctrl,
  output logic [W-1:0]    dout
);
  logic [LG-1:0] hot;
  logic [W-1:0]  cand [LG];

  perm_sel_decode #(.LG(LG), .SELW(SELW)) u_dec (
    .sel (sel),
    .hot (hot)
  );

  // one candidate row of exchange switches per stage type
  for (genvar s = 0; s < LG; s++) begin : g_stage
    for (genvar k = 0; k < HALF; k++) begin : g_sw
      localparam int unsigned LO = ((k >> s) << (s + 1)) | (k & ((1 << s) - 1));
      localparam int unsigned HI = LO + (1 << s);
      assign cand[s][LO] = ctrl[k] ? din[HI] : din[LO];
      assign cand[s][HI] = ctrl[k] ? din[LO] : din[HI];
    end
  end

  always_comb begin
    dout = din;
    for (int s = 0; s < LG; s++) begin
      if (hot[s]) dout = cand[s];
    end
  end
endmodule

// File: rtl/perm2_unit.sv
module perm2_unit #(
  parameter int unsigned W     = perm2_pkg::DATA_W,
  parameter int unsigned SEL_W = perm2_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_vld,
  input  logic [W-1:0]     op_data,
  input  logic [W-1:0]     op_cfg,
  input  logic [SEL_W-1:0] sel_first,
  input  logic [SEL_W-1:0] sel_second,
  output logic             res_vld,
  output logic [W-1:0]     res_data
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] mid;
  logic [W-1:0] perm;
  logic [W-1:0] data_nxt;
  logic         vld_nxt;

  perm_stage #(.W(W), .SELW(SEL_W)) u_first (
    .din  (op_data),
    .sel  (sel_first),
    .ctrl (op_cfg[W-1:HALF]),
    .dout (mid)
  );

  perm_stage #(.W(W), .SELW(SEL_W)) u_second (
    .din  (mid),
    .sel  (sel_second),
    .ctrl (op_cfg[HALF-1:0]),
    .dout (perm)
  );

  always_comb begin
    vld_nxt  = op_vld;
    data_nxt = res_data;
    if (op_vld) data_nxt = perm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_vld <= 1'b0;
    else        res_vld <= vld_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_data <= '0;
    else if (op_vld) res_data <= data_nxt;
  end
endmodule

// File: rtl/perm2_unit_chk.sv
module perm2_unit_chk #(
  parameter int unsigned W     = 64,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_vld,
  input logic [W-1:0]     op_data,
  input logic [W-1:0]     op_cfg,
  input logic [SEL_W-1:0] sel_first,
  input logic [SEL_W-1:0] sel_second,
  input logic             res_vld,
  input logic [W-1:0]     res_data
);
  localparam int unsigned LG = $clog2(W);

  always @(posedge clk) begin
    if (!rst_n) p_rst_idle_r1: assert (!res_vld);
  end

  p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> res_vld);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> (!res_vld && $stable(res_data)));

  p_ones_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> ($countones(res_data) == $countones($past(op_data))));

  p_pass_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && sel_first >= SEL_W'(LG) && sel_second >= SEL_W'(LG))
      |=> (res_data == $past(op_data)));

  p_zero_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_cfg == '0) |=> (res_data == $past(op_data)));

  p_self_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && sel_first == sel_second && op_cfg[W-1:W/2] == op_cfg[W/2-1:0])
      |=> (res_data == $past(op_data)));
endmodule

bind perm2_unit perm2_unit_chk #(.W(W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/sim_perm2_unit.sv
module sim_perm2_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        op_vld;
  logic [63:0] op_data;
  logic [63:0] op_cfg;
  logic [2:0]  sel_first;
  logic [2:0]  sel_second;
  logic        res_vld;
  logic [63:0] res_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_seen;

  perm2_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_data(op_data),
    .op_cfg(op_cfg), .sel_first(sel_first), .sel_second(sel_second),
    .res_vld(res_vld), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref_stage(input logic [63:0] x, input int s,
                                            input logic [31:0] c);
    logic [63:0] y;
    if (s > 5) return x;
    for (int i = 0; i < 64; i++) begin
      int k;
      k = ((i >> (s + 1)) << s) | (i & ((1 << s) - 1));
      y[i] = c[k] ? x[i ^ (1 << s)] : x[i];
    end
    return y;
  endfunction

  function automatic logic [63:0] ref_op(input logic [63:0] x, input logic [63:0] c,
                                         input int a, input int b);
    return ref_stage(ref_stage(x, a, c[63:32]), b, c[31:0]);
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input logic [63:0] c, input int a,
                       input int b, input logic [63:0] exp, input string tag);
    op_data    = d;
    op_cfg     = c;
    sel_first  = 3'(a);
    sel_second = 3'(b);
    op_vld     = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    op_vld = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && res_vld) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected result", {63'd0, res_vld}, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, res_data, e);
          last_seen = res_data;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] cfgs [6];
    int pa [6] = '{5, 3, 1, 0, 2, 4};
    int pb [6] = '{4, 2, 0, 1, 3, 5};
    logic [63:0] d, c, cur;

    rst_n = 1'b0; op_vld = 1'b0; op_data = '0; op_cfg = '0;
    sel_first = '0; sel_second = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, res_vld}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {63'd0, res_vld}, 64'd0);

    // R3 explicit switch positions
    drive(64'h1, {32'h1, 32'h0}, 0, 7, 64'h2, "R3 stage0 sw0");
    drive(64'h1 << 3, {32'h8, 32'h0}, 5, 7, 64'h1 << 35, "R3 stage5 sw3");
    drive(64'h1 << 9, {32'h20, 32'h0}, 2, 7, 64'h1 << 13, "R3 stage2 sw5");
    drive(64'h1 << 9, {32'h10, 32'h0}, 2, 7, 64'h1 << 9, "R3 stage2 other sw");

    // R4 half and order
    drive(64'h1, {32'h1, 32'h1}, 0, 1, 64'h2, "R4 order 0 then 1");
    drive(64'h1, {32'h1, 32'h1}, 1, 0, 64'h4, "R4 order 1 then 0");
    drive(64'h1, {32'h0, 32'h1}, 0, 1, 64'h4, "R4 lower half second");

    // R5 pass selectors
    d = rnd64();
    drive(d, '1, 6, 7, d, "R5 both pass");
    d = rnd64(); c = {32'hffff_ffff, rnd64()} & 64'hffff_ffff_ffff_ffff;
    drive(d, c, 7, 3, ref_stage(d, 3, c[31:0]), "R5 first pass");
    d = rnd64(); c = rnd64();
    drive(d, c, 4, 6, ref_stage(d, 4, c[63:32]), "R5 second pass");

    // R6 zero config
    d = rnd64();
    drive(d, 64'd0, 5, 0, d, "R6 zero cfg");

    // R8 same stage twice
    d = rnd64(); c[63:32] = $urandom; c[31:0] = c[63:32];
    drive(d, c, 4, 4, d, "R8 self inverse");

    // R3 random back-to-back
    for (int i = 0; i < 40; i++) begin
      int a, b;
      a = $urandom_range(0, 7); b = $urandom_range(0, 7);
      d = rnd64(); c = rnd64();
      drive(d, c, a, b, ref_op(d, c, a, b), "R3 random op");
    end
    drain();

    // R2 hold while idle
    op_data = rnd64(); op_cfg = rnd64(); sel_first = 3'd2; sel_second = 3'd1;
    @(negedge clk); @(negedge clk);
    check("R2 no valid when idle", {63'd0, res_vld}, 64'd0);
    check("R2 data held when idle", res_data, last_seen);

    // R7 six-step chain
    for (int s = 0; s < 6; s++) cfgs[s] = rnd64();
    for (int w = 0; w < 12; w++) begin
      d = (w < 6) ? (64'h1 << $urandom_range(0, 63)) : rnd64();
      cur = d;
      for (int s = 0; s < 6; s++) begin
        logic [63:0] e;
        e = ref_op(cur, cfgs[s], pa[s], pb[s]);
        drive(cur, cfgs[s], pa[s], pb[s], e, "R7 chain step");
        cur = e;
      end
      #2;
      check("R7 chain result", res_data, cur);
      if (w < 6) check("R7 single bit kept", 64'($countones(res_data)), 64'd1);
    end
    drain();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule